// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block puts a private bank of 16-bit registers behind one 64-bit command word. A host writes the command word through a simple synchronous register port. The word holds three things: a direction flag, a 20-bit indirect address and a 16-bit data field. A fixed number of cycles later the block carries out the access.

- On a write, the data field is stored in the addressed entry.
- On a read, the entry is copied back into the data field of the same word.

When the access is done, completion flags are ORed into the word. The host then reads the command word back to collect the flags and, for a read, the returned data.

Bits of the command word are numbered most-significant-first in the field definitions below. Bit 0 is the MSB, which is vector index 63 of the ports. The register bank has DEPTH entries, 256 by default. It is indexed by the low log2(DEPTH) bits of the address field.

Top module: `regwin_bridge`

## Requirements
- R1: After a synchronous active-low reset, the command word, `host_rdata` and `busy` are all zero, and every bank entry reads back as zero.
- R2: A command with bit 0 (index 63) equal to 0 stores bits 48..63 (index 15:0) into the entry selected by bits 12..31 (index 51:32).
- R3: A command with bit 0 equal to 1 replaces bits 48..63 of the command word with the selected entry. All other bits keep their written values, apart from the flags of R5.
- R4: When a write completes, 0x0000_0000_8200_0000 is ORed into the command word. This sets bits 32 and 38 (index 31 and 25).
- R5: When a read completes, 0x0000_0000_8300_0000 is ORed into the command word. This sets bits 32, 38 and 39 (index 31, 25 and 24).
- R6: `busy` rises on the edge that accepts a command. It stays high for LAT cycles (default 2), and the access completes on the LAT-th edge after acceptance.
- R7: A `host_wr` pulse seen while `busy` is high is ignored. This includes a pulse on the completion edge.
- R8: An accepted command replaces the whole command word, so flags left by an earlier command are cleared before the new flags are ORed in.
- R9: Address bits above the bank index are ignored, so addresses that agree in their low index bits select the same entry.
- R10: `host_rdata` loads the command word on an edge where `host_rd` is high and holds otherwise. A read strobe on the completion edge returns the word as it was before completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Command word write strobe |
| host_wdata | input | 64 | Command word to write |
| host_rd | input | 1 | Command word read strobe |
| host_rdata | output | 64 | Command word captured by the last read strobe |
| busy | output | 1 | Access in progress |

## Verification
Three host actions can land on the completion edge: a new command write, a host read, and the bank update or fetch itself. The bench holds `host_wr` high with a junk word through the busy window, up to and including the completion edge, and raises `host_rd` on that same edge. It then judges two things. The read must return the word as it stood before completion. The later read-back must show the first command's result with the junk word discarded. Random commands, some with this overlap and some without, are compared against a reference bank kept in the bench.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int CMD_W  = 64;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    // Vector indices of the fields (MSB-first bit k maps to index 63-k)
    localparam int DIR_IDX   = 63;
    localparam int ADDR_LSB  = 32;
    localparam int DATA_LSB  = 0;
    localparam int ACK_IDX   = 31;
    localparam int OK_IDX    = 25;
    localparam int RDONE_IDX = 24;

    localparam logic [CMD_W-1:0] WR_FLAGS = (64'd1 << ACK_IDX) | (64'd1 << OK_IDX);
    localparam logic [CMD_W-1:0] RD_FLAGS = WR_FLAGS | (64'd1 << RDONE_IDX);

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_fields_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [CMD_W-1:0] cmd,
    output cmd_fields_t      fields,
    output logic [IDX_W-1:0] idx
);
    logic unused_bits;

    always_comb begin
        fields.is_read = cmd[DIR_IDX];
        fields.addr    = cmd[ADDR_LSB +: ADDR_W];
        fields.data    = cmd[DATA_LSB +: DATA_W];
        // upper address bits do not take part in entry selection
        idx            = fields.addr[IDX_W-1:0];
    end

    assign unused_bits = ^cmd;
endmodule

// File: rtl/regwin_store.sv
module regwin_store
    import regwin_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx];

    // R2
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int LAT = 2,
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CMD_W-1:0]  host_wdata,
    input  logic              host_rd,
    input  cmd_fields_t       fields,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CMD_W-1:0]  cmd,
    output logic [CMD_W-1:0]  host_rdata,
    output logic              busy,
    output logic              mem_we
);
    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [CMD_W-1:0] rdata;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       done;

    always_comb begin
        st_d = st_q;
        done = st_q.busy && (st_q.cnt == CNT_W'(LAT - 1));
        mem_we = 1'b0;

        // host reads see the word as registered, before this edge's update
        if (host_rd) begin
            st_d.rdata = st_q.cmd;
        end

        if (done) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            if (fields.is_read) begin
                st_d.cmd = st_q.cmd | RD_FLAGS;
                st_d.cmd[DATA_LSB +: DATA_W] = mem_rdata;
            end else begin
                st_d.cmd = st_q.cmd | WR_FLAGS;
                mem_we   = 1'b1;
            end
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (host_wr) begin
            st_d.cmd  = host_wdata;
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd        = st_q.cmd;
    assign host_rdata = st_q.rdata;
    assign busy       = st_q.busy;

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(host_wr));
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done) |=> $stable(st_q.cmd));
    // R8
    new_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.cmd == $past(host_wdata)));
    // R4
    wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && !st_q.cmd[DIR_IDX]) |-> (st_q.cmd[ACK_IDX] && st_q.cmd[OK_IDX]));
    // R5
    rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && st_q.cmd[DIR_IDX])
            |-> (st_q.cmd[ACK_IDX] && st_q.cmd[OK_IDX] && st_q.cmd[RDONE_IDX]));
    // R3
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && st_q.cmd[DIR_IDX])
            |-> (st_q.cmd[CMD_W-1:ADDR_LSB] == $past(st_q.cmd[CMD_W-1:ADDR_LSB])));
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(st_q.rdata));
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LAT   = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [63:0] host_wdata,
    input  logic        host_rd,
    output logic [63:0] host_rdata,
    output logic        busy
);
    logic [CMD_W-1:0]  cmd_w;
    cmd_fields_t       fields_w;
    logic [IDX_W-1:0]  idx_w;
    logic [DATA_W-1:0] mem_rdata_w;
    logic              mem_we_w;

    regwin_decode #(.IDX_W(IDX_W)) u_decode (
        .cmd    (cmd_w),
        .fields (fields_w),
        .idx    (idx_w)
    );

    regwin_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we_w),
        .idx   (idx_w),
        .wdata (fields_w.data),
        .rdata (mem_rdata_w)
    );

    regwin_seq #(.LAT(LAT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .fields     (fields_w),
        .mem_rdata  (mem_rdata_w),
        .cmd        (cmd_w),
        .host_rdata (host_rdata),
        .busy       (busy),
        .mem_we     (mem_we_w)
    );
endmodule

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;
    localparam int LAT   = 2;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [63:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [63:0] host_rdata;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    regwin_bridge #(.DEPTH(DEPTH), .LAT(LAT)) u_regwin_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .busy(busy)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] predict(input logic [63:0] w);
        logic [63:0] r;
        if (w[63]) begin
            r = {w[63:16], ref_mem[w[39:32]]} | 64'h0000_0000_8300_0000;
        end else begin
            r = w | 64'h0000_0000_8200_0000;
        end
        return r;
    endfunction

    function automatic logic [63:0] mk(input bit rd, input logic [19:0] a, input logic [15:0] d,
                                       input logic [63:0] noise);
        logic [63:0] w;
        w = noise;
        w[63] = rd;
        w[51:32] = a;
        w[15:0] = d;
        return w;
    endfunction

    // read the command word through the host port
    task automatic host_read(output logic [63:0] v);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    // issue one command; with stress, hold a junk write through the busy
    // window and strobe a read on the completion edge
    task automatic run_cmd(input logic [63:0] w, input logic [63:0] junk, input bit stress,
                           output logic [63:0] result);
        logic [63:0] exp;
        exp = predict(w);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = w;
        @(negedge clk);
        check("R6 busy after accept", {63'd0, busy}, 64'd1);
        if (stress) host_wdata = junk; else host_wr = 1'b0;
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            check("R6 busy held", {63'd0, busy}, 64'd1);
        end
        host_rd = stress;
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
        check("R6 busy clears", {63'd0, busy}, 64'd0);
        if (stress) check("R10 read on completion edge", host_rdata, w);
        if (!w[63]) ref_mem[w[39:32]] = w[15:0];
        host_read(result);
        if (stress) check("R7 write while busy ignored", result, exp);
        else if (w[63]) check("R3 R5 read result", result, exp);
        else check("R2 R4 write result", result, exp);
    endtask

    initial begin
        logic [63:0] r;
        logic [63:0] w;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 busy reset", {63'd0, busy}, 64'd0);
        check("R1 rdata reset", host_rdata, 64'd0);
        host_read(r);
        check("R1 word reset", r, 64'd0);
        run_cmd(mk(1'b1, 20'h00077, 16'hFFFF, 64'd0), 64'd0, 1'b0, r);
        check("R1 entry reset", {48'd0, r[15:0]}, 64'd0);

        // R2 / R9 aliasing of upper address bits
        run_cmd(mk(1'b0, 20'hABC45, 16'h5A5A, 64'h0123_0000_0000_0000), 64'd0, 1'b0, r);
        run_cmd(mk(1'b1, 20'h00045, 16'h0000, 64'd0), 64'd0, 1'b0, r);
        check("R9 alias low", {48'd0, r[15:0]}, 64'h5A5A);
        run_cmd(mk(1'b1, 20'hFFF45, 16'h1111, 64'd0), 64'd0, 1'b0, r);
        check("R9 alias high", {48'd0, r[15:0]}, 64'h5A5A);

        // R8: read leaves bit index 24 set; next write must drop it
        run_cmd(mk(1'b0, 20'h00010, 16'hBEEF, 64'd0), 64'd0, 1'b0, r);
        check("R8 flag cleared", {63'd0, r[24]}, 64'd0);

        // R3: other bits untouched on read
        w = mk(1'b1, 20'h00045, 16'h0000, 64'h7000_0000_4444_0000);
        run_cmd(w, 64'd0, 1'b0, r);
        check("R3 upper kept", {16'd0, r[63:16]}, {16'd0, w[63:16] | 48'h0000_0000_8300});

        // R7 / R10 collision on completion edge
        run_cmd(mk(1'b0, 20'h00020, 16'hC0DE, 64'd0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, r);
        run_cmd(mk(1'b1, 20'h00020, 16'h0000, 64'd0), mk(1'b0, 20'h00020, 16'hDEAD, 64'd0), 1'b1, r);
        check("R7 entry unchanged", {48'd0, r[15:0]}, 64'hC0DE);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [63:0] noise;
            logic [19:0] a;
            noise = {$urandom, $urandom};
            a = {$urandom % 20'hFFFFF}[19:0];
            a[7:0] = 8'($urandom % 16);
            run_cmd(mk(1'($urandom % 2), a, 16'($urandom), noise), {$urandom, $urandom},
                    ($urandom % 4) == 0, r);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule